// File: doc/BRIEF.md
# Processor Machine-Cycle Bus Sequencer

This block produces the bus activity an 8-bit processor needs to carry out one instruction. An external decoder gives it a one-cycle request. The request says how many operand bytes follow the opcode, whether the opcode fetch is stretched, and which data transfer, if any, ends the instruction. The sequencer then runs an opcode fetch, up to two operand fetches, and at most one memory or I/O transfer. It steps each machine cycle through numbered clock states (T states), one clock per state.

For every state the sequencer drives the address bus, the memory/I/O select line and the read and write strobes. The address comes either from its own program counter or from the address supplied with the request. It captures the opcode byte into an instruction register, the operand bytes into a bank of temporary registers, and the byte of a data read into a transfer register. When the last cycle finishes it raises a done pulse and is ready for the next request.

Top module: `mcyc_sequencer`

## Requirements
- R1: A request is accepted only while `cyc_o` is 0 (idle). The clock after acceptance is T1 of an opcode fetch. The cycle codes on `cyc_o` are: 0 idle, 1 opcode fetch, 2 operand fetch, 3 memory read, 4 memory write, 5 I/O read, 6 I/O write.
- R2: During opcode and operand fetches `addr` equals the program counter. During memory transfers `addr` equals `req_addr` as captured at acceptance.
- R3: The byte read at the end of T3 of an opcode fetch is loaded into `ir`. The first operand byte goes to `opr_bytes[7:0]` and the second to `opr_bytes[15:8]`, and neither ever reaches `ir`. The byte of a memory or I/O read goes to `xdat`. Registers that are not written keep their value.
- R4: An opcode fetch lasts 4 T states, or 6 when `req_ext` was 1 at acceptance. `tstate` shows 1..N during a cycle and 0 while idle.
- R5: Operand fetches and all transfers last 3 T states. The strobe for the cycle's direction is high exactly in T2 and T3. During a write strobe `dout` carries `req_wdata`.
- R6: `io_m` is 1 during I/O read and write cycles and 0 during memory read and write cycles.
- R7: In I/O cycles both halves of `addr` carry `req_addr[7:0]`.
- R8: The program counter increments by one at the end of each opcode or operand fetch. It holds during transfer cycles.
- R9: `done` is high for exactly the one clock that follows the last T state of the final cycle, with `cyc_o` at 0. `req_ops` of 0, 1 or 2 selects the operand count (values above 2 act as 2). `req_kind` selects the transfer: 0 none, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5..7 none.
- R10: While `rst` is high, the program counter, `ir`, `opr_bytes` and `xdat` are cleared, the sequencer is idle, and `tstate`, `done` and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | input | 1 | request strobe, taken while idle |
| req_ops | input | 2 | number of operand bytes |
| req_ext | input | 1 | stretch the opcode fetch to 6 T states |
| req_kind | input | 3 | transfer selection |
| req_addr | input | 16 | transfer address (I/O port in low byte) |
| req_wdata | input | 8 | byte to write |
| din | input | 8 | read data bus |
| addr | output | 16 | address bus |
| io_m | output | 1 | 1 = I/O space, 0 = memory |
| rd_stb | output | 1 | read strobe |
| wr_stb | output | 1 | write strobe |
| dout | output | 8 | write data bus |
| tstate | output | 3 | current T state, 0 when idle |
| cyc_o | output | 3 | current cycle code |
| done | output | 1 | one-clock completion pulse |
| pc | output | 16 | program counter |
| ir | output | 8 | instruction register |
| opr_bytes | output | 16 | operand registers, first byte low |
| xdat | output | 8 | last transfer read byte |

## Verification
The bench sweeps every combination of operand count, fetch stretch and transfer kind, including the unused kind code. Each cycle is checked state by state against a schedule the bench derives from the requirements. A design that miscounted the stretched fetch would shift every following cycle by two states. One that chained operand fetches wrongly would fetch from the wrong program counter or load the high operand register instead of the low one. An I/O cycle without the port mirrored would show zeros on the upper address byte. A program counter that moved during transfers would put every later opcode address out by one. A mid-instruction reset checks that strobes and registers fall back at once rather than finishing the cycle.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   typedef enum logic [2:0] {
      CY_IDLE = 3'd0,
      CY_OPC  = 3'd1,
      CY_OPR  = 3'd2,
      CY_MRD  = 3'd3,
      CY_MWR  = 3'd4,
      CY_IORD = 3'd5,
      CY_IOWR = 3'd6
   } cyc_e;

   function automatic logic cyc_is_read(cyc_e c);
      return (c == CY_OPC) || (c == CY_OPR) || (c == CY_MRD) || (c == CY_IORD);
   endfunction

   function automatic logic cyc_is_write(cyc_e c);
      return (c == CY_MWR) || (c == CY_IOWR);
   endfunction

   function automatic logic cyc_is_io(cyc_e c);
      return (c == CY_IORD) || (c == CY_IOWR);
   endfunction
endpackage

// File: rtl/mseq_tstate.sv
module mseq_tstate #(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [TW-1:0] len,
   output logic [TW-1:0] t,
   output logic          last
);
   assign last = (t != '0) && (t == len);

   always_ff @(posedge clk) begin
      if (rst)              t <= '0;
      else if (start)       t <= TW'(1);
      else if (last)        t <= '0;
      else if (t != '0)     t <= t + TW'(1);
   end
endmodule

// File: rtl/mseq_addr.sv
module mseq_addr
   import mseq_pkg::*;
#(
   parameter int AW     = 16,
   parameter int PW     = 8,
   parameter bit MIRROR = 1'b1
) (
   input  cyc_e          cyc,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] xaddr,
   output logic [AW-1:0] addr,
   output logic          io_m
);
   logic [AW-1:0] port_addr;

   generate
      if (MIRROR) begin : g_mirror
         if (AW != 2 * PW) begin : g_bad
            $error("mseq_addr: mirroring needs AW == 2*PW");
         end
         assign port_addr = {xaddr[PW-1:0], xaddr[PW-1:0]};
      end else begin : g_zext
         assign port_addr = {{(AW-PW){1'b0}}, xaddr[PW-1:0]};
      end
   endgenerate

   assign io_m = cyc_is_io(cyc);

   always_comb begin
      unique case (cyc)
         CY_IDLE, CY_OPC, CY_OPR: addr = pc;
         CY_IORD, CY_IOWR:        addr = port_addr;
         default:                 addr = xaddr;
      endcase
   end
endmodule

// File: rtl/mseq_regs.sv
module mseq_regs #(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int NOPR = 2,
   parameter int SW   = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pc_inc,
   input  logic             ld_ir,
   input  logic             ld_opr,
   input  logic [SW-1:0]    opr_sel,
   input  logic             ld_x,
   input  logic [DW-1:0]    din,
   output logic [AW-1:0]    pc,
   output logic [DW-1:0]    ir,
   output logic [NOPR*DW-1:0] opr_flat,
   output logic [DW-1:0]    xdat
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pc   <= '0;
         ir   <= '0;
         xdat <= '0;
      end else begin
         if (pc_inc) pc   <= pc + AW'(1);
         if (ld_ir)  ir   <= din;
         if (ld_x)   xdat <= din;
      end
   end

   generate
      for (genvar g = 0; g < NOPR; g++) begin : g_opr
         always_ff @(posedge clk) begin
            if (rst)
               opr_flat[g*DW +: DW] <= '0;
            else if (ld_opr && (opr_sel == SW'(g)))
               opr_flat[g*DW +: DW] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
   import mseq_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter int PW      = 8,
   parameter int NOPR    = 2,
   parameter int OPC_T   = 4,
   parameter int OPC_XT  = 6,
   parameter int SHORT_T = 3,
   parameter bit MIRROR  = 1'b1,
   localparam int OCW    = $clog2(NOPR + 1),
   localparam int SW     = (NOPR > 1) ? $clog2(NOPR) : 1,
   localparam int TW     = $clog2(OPC_XT + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [OCW-1:0]    req_ops,
   input  logic              req_ext,
   input  logic [2:0]        req_kind,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [DW-1:0]     din,
   output logic [AW-1:0]     addr,
   output logic              io_m,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [DW-1:0]     dout,
   output logic [TW-1:0]     tstate,
   output logic [2:0]        cyc_o,
   output logic              done,
   output logic [AW-1:0]     pc,
   output logic [DW-1:0]     ir,
   output logic [NOPR*DW-1:0] opr_bytes,
   output logic [DW-1:0]     xdat
);
   generate
      if (SHORT_T < 3 || OPC_T < 3 || OPC_XT < OPC_T) begin : g_bad_t
         $error("mcyc_sequencer: T-state counts must reach T3 and OPC_XT >= OPC_T");
      end
      if (NOPR < 1) begin : g_bad_n
         $error("mcyc_sequencer: NOPR must be at least 1");
      end
   endgenerate

   cyc_e          cyc_q, xcyc_q, nxt;
   logic [OCW-1:0] ops_q;
   logic [SW-1:0]  oidx_q;
   logic           ext_q, done_q;
   logic [AW-1:0]  xaddr_q;
   logic [DW-1:0]  wdata_q;
   logic [TW-1:0]  t, len;
   logic           last, accept, start, sample;

   assign accept = (cyc_q == CY_IDLE) && req_valid;
   assign len    = (cyc_q == CY_OPC) ? (ext_q ? TW'(OPC_XT) : TW'(OPC_T)) : TW'(SHORT_T);
   assign start  = accept || (last && (nxt != CY_IDLE));
   assign sample = (t == TW'(3)) && cyc_is_read(cyc_q);

   always_comb begin
      unique case (cyc_q)
         CY_OPC:  nxt = (ops_q != '0)      ? CY_OPR : xcyc_q;
         CY_OPR:  nxt = (ops_q > OCW'(1))  ? CY_OPR : xcyc_q;
         default: nxt = CY_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q   <= CY_IDLE;
         xcyc_q  <= CY_IDLE;
         ops_q   <= '0;
         oidx_q  <= '0;
         ext_q   <= 1'b0;
         done_q  <= 1'b0;
         xaddr_q <= '0;
         wdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            cyc_q   <= CY_OPC;
            ops_q   <= (req_ops > OCW'(NOPR)) ? OCW'(NOPR) : req_ops;
            oidx_q  <= '0;
            ext_q   <= req_ext;
            xaddr_q <= req_addr;
            wdata_q <= req_wdata;
            unique case (req_kind)
               3'd1:    xcyc_q <= CY_MRD;
               3'd2:    xcyc_q <= CY_MWR;
               3'd3:    xcyc_q <= CY_IORD;
               3'd4:    xcyc_q <= CY_IOWR;
               default: xcyc_q <= CY_IDLE;
            endcase
         end else if (last) begin
            cyc_q <= nxt;
            if (nxt == CY_IDLE) done_q <= 1'b1;
            if (cyc_q == CY_OPR) begin
               ops_q  <= ops_q - OCW'(1);
               oidx_q <= oidx_q + SW'(1);
            end
         end
      end
   end

   mseq_tstate #(.TW(TW)) u_tstate (
      .clk(clk), .rst(rst), .start(start), .len(len), .t(t), .last(last)
   );

   mseq_addr #(.AW(AW), .PW(PW), .MIRROR(MIRROR)) u_addr (
      .cyc(cyc_q), .pc(pc), .xaddr(xaddr_q), .addr(addr), .io_m(io_m)
   );

   mseq_regs #(.AW(AW), .DW(DW), .NOPR(NOPR), .SW(SW)) u_regs (
      .clk(clk), .rst(rst),
      .pc_inc(last && ((cyc_q == CY_OPC) || (cyc_q == CY_OPR))),
      .ld_ir(sample && (cyc_q == CY_OPC)),
      .ld_opr(sample && (cyc_q == CY_OPR)),
      .opr_sel(oidx_q),
      .ld_x(sample && ((cyc_q == CY_MRD) || (cyc_q == CY_IORD))),
      .din(din),
      .pc(pc), .ir(ir), .opr_flat(opr_bytes), .xdat(xdat)
   );

   assign rd_stb = ((t == TW'(2)) || (t == TW'(3))) && cyc_is_read(cyc_q);
   assign wr_stb = ((t == TW'(2)) || (t == TW'(3))) && cyc_is_write(cyc_q);
   assign dout   = wdata_q;
   assign tstate = t;
   assign cyc_o  = cyc_q;
   assign done   = done_q;
endmodule

// File: rtl/mcyc_sequencer_chk.sv
module mcyc_sequencer_chk #(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int NOPR = 2,
   parameter int TW   = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [AW-1:0]     addr,
   input logic              io_m,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [TW-1:0]     tstate,
   input logic [2:0]        cyc_o,
   input logic              done,
   input logic [AW-1:0]     pc,
   input logic [DW-1:0]     ir
);
   p_first_opc_r1: assert property (@(posedge clk) disable iff (rst)
      (cyc_o != 3'd0 && $past(cyc_o) == 3'd0) |-> cyc_o == 3'd1);

   p_long_only_opc_r4: assert property (@(posedge clk) disable iff (rst)
      (tstate > TW'(4)) |-> cyc_o == 3'd1);

   p_strobe_window_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_stb || wr_stb) |-> (tstate == TW'(2) || tstate == TW'(3)));

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(rd_stb && wr_stb));

   p_io_high_r6: assert property (@(posedge clk) disable iff (rst)
      (cyc_o == 3'd5 || cyc_o == 3'd6) |-> io_m);

   p_mem_low_r6: assert property (@(posedge clk) disable iff (rst)
      (cyc_o == 3'd3 || cyc_o == 3'd4) |-> !io_m);

   p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (cyc_o >= 3'd3 && cyc_o <= 3'd6) |=> $stable(pc));

   p_ir_untouched_r3: assert property (@(posedge clk) disable iff (rst)
      (cyc_o == 3'd2) |=> $stable(ir));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      done |-> (cyc_o == 3'd0 && !rd_stb && !wr_stb));

   p_reset_clears_r10: assert property (@(posedge clk)
      rst |=> (pc == '0 && ir == '0 && cyc_o == 3'd0 && !rd_stb && !wr_stb));
endmodule

bind mcyc_sequencer mcyc_sequencer_chk #(.AW(AW), .DW(DW), .NOPR(NOPR), .TW(TW)) u_chk (
   .clk(clk), .rst(rst), .addr(addr), .io_m(io_m), .rd_stb(rd_stb), .wr_stb(wr_stb),
   .tstate(tstate), .cyc_o(cyc_o), .done(done), .pc(pc), .ir(ir)
);

// File: tb/mcyc_sequencer_bench.sv
module mcyc_sequencer_bench;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst, req_valid, req_ext;
   logic [1:0]  req_ops;
   logic [2:0]  req_kind;
   logic [15:0] req_addr;
   logic [7:0]  req_wdata, din;
   logic [15:0] addr, pc;
   logic        io_m, rd_stb, wr_stb, done;
   logic [7:0]  dout, ir, xdat;
   logic [2:0]  tstate, cyc_o;
   logic [15:0] opr_bytes;

   int checks = 0;
   int errors = 0;

   function automatic logic [7:0] mem_f(logic [15:0] a);
      return a[7:0] + 8'(3 * a[15:8]) + 8'h21;
   endfunction

   assign din = mem_f(addr);

   mcyc_sequencer u_mcyc_sequencer (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ops(req_ops), .req_ext(req_ext),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata), .din(din),
      .addr(addr), .io_m(io_m), .rd_stb(rd_stb), .wr_stb(wr_stb), .dout(dout),
      .tstate(tstate), .cyc_o(cyc_o), .done(done), .pc(pc), .ir(ir),
      .opr_bytes(opr_bytes), .xdat(xdat)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_cycle(input int code, input int len, input logic [15:0] ea,
                            input bit rdk, input bit wrk, input bit iom,
                            input logic [7:0] wd, input string areq, input logic [15:0] epc);
      for (int t = 1; t <= len; t++) begin
         bit strb;
         strb = (t == 2) || (t == 3);
         chk(tstate == 3'(t), (code == 1) ? "R4" : "R5", "tstate", tstate, t);
         chk(cyc_o == 3'(code), (code == 1 && t == 1) ? "R1" : "R2", "cycle code", cyc_o, code);
         chk(addr == ea, areq, "address", addr, ea);
         chk(io_m == iom, "R6", "io_m", io_m, iom);
         chk(rd_stb == (rdk && strb), "R5", "rd_stb", rd_stb, rdk && strb);
         chk(wr_stb == (wrk && strb), "R5", "wr_stb", wr_stb, wrk && strb);
         if (wrk && strb) chk(dout == wd, "R5", "write data", dout, wd);
         if (code >= 3) chk(pc == epc, "R8", "pc held in transfer", pc, epc);
         chk(done == 1'b0, "R9", "done during cycle", done, 0);
         @(negedge clk);
      end
   endtask

   task automatic chk_reset_state();
      chk(pc == 16'h0 && ir == 8'h0, "R10", "pc/ir after reset", {pc, ir}, 0);
      chk(opr_bytes == 16'h0 && xdat == 8'h0, "R10", "temps after reset", {opr_bytes, xdat}, 0);
      chk(cyc_o == 3'd0 && tstate == 3'd0, "R10", "idle after reset", {cyc_o, tstate}, 0);
      chk(!rd_stb && !wr_stb && !done, "R10", "strobes after reset", {rd_stb, wr_stb, done}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] epc, xa, ea;
      logic [7:0]  eir, exd, wd;
      logic [7:0]  eopr [2];
      int n;
      rst = 1'b1; req_valid = 1'b0; req_ops = 2'd0; req_ext = 1'b0;
      req_kind = 3'd0; req_addr = 16'h0; req_wdata = 8'h0;
      repeat (3) @(negedge clk);
      chk_reset_state();
      rst = 1'b0;
      @(negedge clk);
      epc = 16'h0; eir = 8'h0; exd = 8'h0; eopr[0] = 8'h0; eopr[1] = 8'h0;
      n = 0;
      for (int ops = 0; ops <= 3; ops++) begin
         for (int ext = 0; ext <= 1; ext++) begin
            for (int k = 0; k <= 5; k++) begin
               int nops;
               nops = (ops > 2) ? 2 : ops;
               xa = 16'h1234 + 16'(n * 16'h0301);
               wd = 8'(n * 7 + 3);
               req_valid = 1'b1; req_ops = 2'(ops); req_ext = ext[0];
               req_kind = 3'(k); req_addr = xa; req_wdata = wd;
               @(negedge clk);
               req_valid = 1'b0;
               run_cycle(1, ext ? 6 : 4, epc, 1'b1, 1'b0, 1'b0, 8'h0, "R2", epc);
               eir = mem_f(epc);
               epc = epc + 16'h1;
               for (int j = 0; j < nops; j++) begin
                  run_cycle(2, 3, epc, 1'b1, 1'b0, 1'b0, 8'h0, "R2", epc);
                  eopr[j] = mem_f(epc);
                  epc = epc + 16'h1;
               end
               if (k >= 1 && k <= 4) begin
                  bit io, rd;
                  io = (k >= 3);
                  rd = (k == 1) || (k == 3);
                  ea = io ? {xa[7:0], xa[7:0]} : xa;
                  run_cycle(k + 2, 3, ea, rd, !rd, io, wd, io ? "R7" : "R2", epc);
                  if (rd) exd = mem_f(ea);
               end
               chk(done == 1'b1, "R9", "done pulse", done, 1);
               chk(cyc_o == 3'd0, "R9", "idle at done", cyc_o, 0);
               chk(pc == epc, "R8", "pc after instruction", pc, epc);
               chk(ir == eir, "R3", "instruction register", ir, eir);
               chk(opr_bytes[7:0] == eopr[0], "R3", "first operand", opr_bytes[7:0], eopr[0]);
               chk(opr_bytes[15:8] == eopr[1], "R3", "second operand", opr_bytes[15:8], eopr[1]);
               chk(xdat == exd, "R3", "transfer read byte", xdat, exd);
               @(negedge clk);
               chk(done == 1'b0, "R9", "done one clock only", done, 0);
               n++;
            end
         end
      end
      // reset in the middle of a read strobe
      req_valid = 1'b1; req_ops = 2'd2; req_ext = 1'b0; req_kind = 3'd1;
      req_addr = 16'hBEEF; req_wdata = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(rd_stb == 1'b1, "R5", "strobe before reset", rd_stb, 1);
      rst = 1'b1;
      @(negedge clk);
      chk_reset_state();
      rst = 1'b0;
      @(negedge clk);
      chk(cyc_o == 3'd0 && pc == 16'h0, "R10", "stays idle after reset", {cyc_o, pc}, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule